// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Loader

This block receives configuration words for a frequency-synthesizer control core over a three-wire serial link made of a serial clock, a data line and a load strobe. All three wires are asynchronous to the core clock. Each is brought into the core domain through a synchronizer. The block then watches for rising edges of the serial clock and shifts the data bit into a 20-bit register, first bit in the most significant position, as long as the load strobe is low.

A rising edge of the load strobe moves the register contents into one holding register. The two bits received last form a select code that picks the destination:
- the 18-bit main-divider word,
- the 13-bit reference-divider word together with three test flags,
- the standby and switch-output control pair.

Each destination takes a different slice of the 18 payload bits. The held fields drive the divider and control logic directly. The block also qualifies a raw lock indication from the phase detector, using the first test flag and the standby bit.

Top module: `pll_prog_loader`

## Requirements
- R1: A synchronous active-high reset sets the main word to 0, the reference word to 0, the test flags to 3'b100, standby to 0 and switch to 0.
- R2: While the load strobe is low, each rising serial-clock edge shifts the data bit into the 20-bit register, first bit at the MSB. Serial-clock edges that arrive while the load strobe is high leave the register unchanged.
- R3: The select code is {19th bit, 20th bit}. When the 20th bit is 0 (codes 00 and 10), all 18 payload bits (bits 1..18, bit 1 = MSB) load the main-divider word.
- R4: Code 11 loads payload bits [15:3] into the reference word and payload bits [2:0] into the test flags, where flag bit 2 is the first flag. Payload bits [17:16] are ignored.
- R5: Code 01 loads payload bit 17 into standby and payload bit 16 into switch. All other payload bits are ignored.
- R6: A transfer changes only the destination its code selects. The other held values keep their contents.
- R7: A transfer happens exactly once per rising edge of the load strobe. Holding the strobe high causes no further transfer.
- R8: The lock output is registered. It is 0 while the first test flag is 0, otherwise 1 while standby is set, otherwise it follows the raw lock input.
- R9: Held values persist in standby, and writes are still accepted while standby is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_load | input | 1 | Load strobe, asynchronous |
| lock_raw | input | 1 | Raw lock indication from the phase detector |
| main_div | output | 18 | Held main-divider word |
| ref_div | output | 13 | Held reference-divider word |
| test_flags | output | 3 | Held test flags, bit 2 = first flag |
| standby | output | 1 | Held standby bit |
| sw_out | output | 1 | Held switch-output bit |
| lock_out | output | 1 | Qualified lock output |

## Verification
The bench writes every select code. A code decoded from the wrong bit pair would put a word in the wrong holding register, and a misaligned slice would show up as a wrong reference value, because the discarded payload bits are filled with ones. It checks that a control write and a reference write leave the main word untouched. It toggles the serial clock while the strobe is held high, which a design that shifts or re-transfers in that state would expose. It also checks lock gating under a cleared first flag and under standby, and checks that a main-word write made during standby lands.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_MAIN_A = 2'b00,
    SEL_CTRL   = 2'b01,
    SEL_MAIN_B = 2'b10,
    SEL_REF    = 2'b11
  } dest_sel_e;
endpackage

// File: rtl/pll_prog_sync.sv
module pll_prog_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d_i;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pll_prog_shifter.sv
module pll_prog_shifter #(
  parameter int SR_W = 20
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_s,
  input  logic            sdat_s,
  input  logic            load_s,
  output logic [SR_W-1:0] sr_o,
  output logic            xfer_o
);
  logic sclk_d, load_d;
  logic sclk_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      load_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      load_d <= load_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign xfer_o    = load_s & ~load_d;

  always_ff @(posedge clk) begin
    if (rst) sr_o <= '0;
    else if (sclk_rise && !load_s) sr_o <= {sr_o[SR_W-2:0], sdat_s};
  end

  p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    load_s |=> $stable(sr_o));
  p_single_xfer_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_o |=> !xfer_o);
endmodule

// File: rtl/pll_prog_latches.sv
module pll_prog_latches
  import pll_prog_pkg::*;
#(
  parameter int             SR_W    = 20,
  parameter int             R_W     = 13,
  parameter int             TST_W   = 3,
  parameter logic [TST_W-1:0] TST_RST = 3'b100,
  localparam int            PAY_W   = SR_W - SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_i,
  input  logic [SR_W-1:0]  sr_i,
  output logic [PAY_W-1:0] n_q,
  output logic [R_W-1:0]   r_q,
  output logic [TST_W-1:0] tst_q,
  output logic             ps_q,
  output logic             sw_q
);
  logic [PAY_W-1:0] pay;
  dest_sel_e        code;

  assign pay  = sr_i[SR_W-1:SEL_W];
  assign code = dest_sel_e'(sr_i[SEL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q   <= '0;
      r_q   <= '0;
      tst_q <= TST_RST;
      ps_q  <= 1'b0;
      sw_q  <= 1'b0;
    end else if (xfer_i) begin
      case (code)
        SEL_MAIN_A, SEL_MAIN_B: n_q <= pay;
        SEL_REF: begin
          r_q   <= pay[R_W+TST_W-1:TST_W];
          tst_q <= pay[TST_W-1:0];
        end
        SEL_CTRL: begin
          ps_q <= pay[PAY_W-1];
          sw_q <= pay[PAY_W-2];
        end
        default: ;
      endcase
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (n_q == '0) && (tst_q == TST_RST) && !ps_q && !sw_q);
  p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !xfer_i |=> $stable(n_q) && $stable(r_q) && $stable(tst_q) && $stable(ps_q) && $stable(sw_q));
  p_main_load_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && !sr_i[0]) |=> n_q == $past(sr_i[SR_W-1:SEL_W]));
  p_ctrl_only_r5: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && sr_i[1:0] == 2'b01) |=> $stable(n_q) && $stable(r_q) && $stable(tst_q));
  p_ref_only_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_i && sr_i[1:0] == 2'b11) |=> $stable(n_q) && $stable(ps_q) && $stable(sw_q));
endmodule

// File: rtl/pll_prog_loader.sv
module pll_prog_loader
  import pll_prog_pkg::*;
#(
  parameter int SR_W        = 20,
  parameter int R_W         = 13,
  parameter int TST_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int PAY_W      = SR_W - SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_data,
  input  logic             ser_load,
  input  logic             lock_raw,
  output logic [PAY_W-1:0] main_div,
  output logic [R_W-1:0]   ref_div,
  output logic [TST_W-1:0] test_flags,
  output logic             standby,
  output logic             sw_out,
  output logic             lock_out
);
  logic [2:0]      wires_s;
  logic [SR_W-1:0] sr;
  logic            xfer;

  pll_prog_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({ser_clk, ser_data, ser_load}),
    .q_o(wires_s)
  );

  pll_prog_shifter #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(wires_s[2]), .sdat_s(wires_s[1]), .load_s(wires_s[0]),
    .sr_o(sr), .xfer_o(xfer)
  );

  pll_prog_latches #(.SR_W(SR_W), .R_W(R_W), .TST_W(TST_W),
                     .TST_RST(TST_W'(1) << (TST_W-1))) u_lat (
    .clk(clk), .rst(rst), .xfer_i(xfer), .sr_i(sr),
    .n_q(main_div), .r_q(ref_div), .tst_q(test_flags),
    .ps_q(standby), .sw_q(sw_out)
  );

  always_ff @(posedge clk) begin
    if (rst) lock_out <= 1'b0;
    else if (!test_flags[TST_W-1]) lock_out <= 1'b0;
    else if (standby) lock_out <= 1'b1;
    else lock_out <= lock_raw;
  end

  p_ld_off_r8: assert property (@(posedge clk) disable iff (rst)
    !test_flags[TST_W-1] |=> !lock_out);
  p_ld_standby_r8: assert property (@(posedge clk) disable iff (rst)
    (test_flags[TST_W-1] && standby) |=> lock_out);
endmodule

// File: tb/pll_prog_loader_test.sv
module pll_prog_loader_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, lock_raw = 1'b0;
  logic [17:0] main_div;
  logic [12:0] ref_div;
  logic [2:0]  test_flags;
  logic        standby, sw_out, lock_out;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pll_prog_loader uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .lock_raw(lock_raw), .main_div(main_div),
    .ref_div(ref_div), .test_flags(test_flags), .standby(standby),
    .sw_out(sw_out), .lock_out(lock_out)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [19:0] w);
    for (int i = 19; i >= 0; i--) begin
      ser_data = w[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    wait_cyc(4);
    ser_load = 1'b1;
    wait_cyc(6);
    ser_load = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_reset;
    chk(main_div, 0, "R1 main");
    chk(ref_div, 0, "R1 ref");
    chk(test_flags, 3'b100, "R1 flags");
    chk({standby, sw_out}, 0, "R1 ctrl");
  endtask

  task automatic t_main;
    send_word({18'd10000, 2'b00});
    chk(main_div, 10000, "R3 code00");
    send_word({18'h2ABCD, 2'b10});
    chk(main_div, 18'h2ABCD, "R3 code10");
    chk(ref_div, 0, "R6 ref untouched");
    chk({standby, sw_out}, 0, "R6 ctrl untouched");
  endtask

  task automatic t_ref;
    send_word({2'b11, 13'd1234, 3'b100, 2'b11});
    chk(ref_div, 1234, "R4 ref");
    chk(test_flags, 3'b100, "R4 flags");
    chk(main_div, 18'h2ABCD, "R6 main untouched");
    send_word({2'b00, 13'h1FFF, 3'b011, 2'b11});
    chk(ref_div, 13'h1FFF, "R4 ref max");
    chk(test_flags, 3'b011, "R4 flags 011");
  endtask

  task automatic t_lock;
    lock_raw = 1'b1;
    wait_cyc(3);
    chk(lock_out, 0, "R8 flag clear forces low");
    send_word({2'b00, 13'd5, 3'b100, 2'b11});
    lock_raw = 1'b0;
    wait_cyc(3);
    chk(lock_out, 0, "R8 follows raw 0");
    lock_raw = 1'b1;
    wait_cyc(3);
    chk(lock_out, 1, "R8 follows raw 1");
  endtask

  task automatic t_ctrl;
    lock_raw = 1'b0;
    send_word({2'b11, 16'hFFFF, 2'b01});
    chk({standby, sw_out}, 2'b11, "R5 ps sw set");
    chk(main_div, 18'h2ABCD, "R5 main untouched");
    chk(ref_div, 5, "R5 ref untouched");
    chk(lock_out, 1, "R8 standby high");
    send_word({18'd4032, 2'b00});
    chk(main_div, 4032, "R9 write in standby");
    chk(ref_div, 5, "R9 ref persists");
    chk(standby, 1, "R9 standby persists");
    send_word({2'b01, 16'h0000, 2'b01});
    chk({standby, sw_out}, 2'b01, "R5 ps clear sw set");
  endtask

  task automatic t_hold;
    ser_load = 1'b1;
    wait_cyc(6);
    for (int i = 0; i < 6; i++) begin
      ser_data = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(4);
      ser_clk = 1'b0;
    end
    chk({standby, sw_out}, 2'b01, "R7 held strobe no change");
    chk(main_div, 4032, "R7 main held");
    ser_load = 1'b0;
    wait_cyc(6);
    ser_load = 1'b1;
    wait_cyc(6);
    ser_load = 1'b0;
    wait_cyc(6);
    chk({standby, sw_out}, 2'b01, "R2 edges ignored during strobe");
    chk(main_div, 4032, "R2 main kept");
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_main();
    t_ref();
    t_lock();
    t_ctrl();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule